// File: doc/BRIEF.md
# Alarm-Driven Supply Enable Controller

This block keeps a second calendar alarm and uses it to switch off an external power-management device at a set time. Software writes a target time as six BCD fields: seconds, minutes, hours, day, month and year. The calendar counter outside the block supplies the current time as a packed BCD vector and a single-cycle pulse on each seconds update. On that pulse the block compares every field. When all six fields match, it sets a sticky event flag. If the interrupt gate is open, it raises an interrupt. If supply control is armed, it releases the supply-enable output.

A typical power-down sequence reads the current time and programs the alarm two seconds ahead. That is the shortest margin that still lands before the next seconds update. Software then arms supply control and waits for the external device to remove power. Once the supply-enable output drops, it stays low until the block is reset. Clearing the flag or disarming the control does not restore it.

Top module: `pwa_ctrl`

## Requirements
- R1: Out of reset, `pwr_en` is 1, `alarm_irq` is 0, the status flag reads 0 and all alarm fields and control bits read 0.
- R2: Word addresses 0 to 5 hold the alarm fields in the order seconds, minutes, hours, day, month, year. Each field is 8 bits, is written from `wdata[7:0]` and reads back with the upper bits at 0. The same order packs `now_bcd`, with seconds in bits 7:0 and year in bits 47:40.
- R3: The compare is evaluated only in a cycle where `sec_tick` is 1. A matching time presented without the pulse leaves the flag at 0.
- R4: A hit requires all six fields to be equal. A difference in any single field gives no hit.
- R5: A hit sets status bit 0 (address 7) on the following clock edge. The bit stays set until a write to address 7 with `wdata[0]`=1. A write to address 7 with `wdata[0]`=0 leaves it unchanged.
- R6: Control address 6 has bit 0 = supply-control arm and bit 1 = interrupt gate. `alarm_irq` is 1 exactly when the status flag is set and the gate bit is 1.
- R7: A hit while the arm bit is 1 drives `pwr_en` to 0 on the next clock edge. It stays 0 after the flag is cleared and the arm bit is cleared, until reset.
- R8: A hit while the arm bit is 0 sets the flag but leaves `pwr_en` at 1.
- R9: When a hit and a flag-clear write occur in the same cycle, the flag ends up set.
- R10: Status bit 1 reads the current `pwr_en` level. Writes to addresses 8 to 15 change nothing, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on addr) |
| sec_tick | input | 1 | One-cycle pulse on each seconds update |
| now_bcd | input | 48 | Current calendar time, six BCD bytes |
| alarm_irq | output | 1 | Alarm interrupt |
| pwr_en | output | 1 | Supply-enable output, 1 = power on |

## Verification
The bench walks a mismatch through each of the six fields in turn. A compare that skipped one field, or wired two fields to the same byte, would fire early on that case. It presents a matching time without the seconds pulse, which catches a compare that runs continuously. It also collides a hit with a flag-clear write, where a design giving priority to the clear would lose the event. The supply output is checked after the flag is cleared and the arm bit dropped, and again after a hit with the arm bit off. A design that ties the output to the flag or to the arm bit would then restore power, or cut it when it should not.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
    localparam int unsigned FIELDS  = 6;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned REG_AW  = 4;
    localparam int unsigned REG_DW  = 32;
    localparam int unsigned TIME_W  = FIELDS * FIELD_W;

    localparam logic [REG_AW-1:0] ADDR_CTRL = REG_AW'(6);
    localparam logic [REG_AW-1:0] ADDR_STAT = REG_AW'(7);

    localparam int unsigned CTRL_ARM_BIT  = 0;
    localparam int unsigned CTRL_IRQ_BIT  = 1;
    localparam int unsigned STAT_FLAG_BIT = 0;
    localparam int unsigned STAT_PWR_BIT  = 1;

    typedef struct packed {
        logic [FIELDS-1:0][FIELD_W-1:0] fld;
        logic                           arm;
        logic                           irq_gate;
    } cfg_t;

    typedef struct packed {
        logic flag;
        logic pwr_on;
    } trip_t;
endpackage

// File: rtl/pwa_regfile.sv
module pwa_regfile
    import pwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [TIME_W-1:0] alarm_vec,
    output logic              arm,
    output logic              irq_gate,
    output logic              flag_clr
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int i = 0; i < FIELDS; i++) begin
                if (addr == REG_AW'(i)) cfg_d.fld[i] = wdata[FIELD_W-1:0];
            end
            if (addr == ADDR_CTRL) begin
                cfg_d.arm      = wdata[CTRL_ARM_BIT];
                cfg_d.irq_gate = wdata[CTRL_IRQ_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign alarm_vec = cfg_q.fld;
    assign arm       = cfg_q.arm;
    assign irq_gate  = cfg_q.irq_gate;
    assign flag_clr  = wr_en && (addr == ADDR_STAT) && wdata[STAT_FLAG_BIT];
endmodule

// File: rtl/pwa_match.sv
module pwa_match
    import pwa_pkg::*;
(
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] now_bcd,
    input  logic [TIME_W-1:0] alarm_vec,
    output logic              hit
);
    logic [FIELDS-1:0] eq;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign eq[g] = (now_bcd[g*FIELD_W +: FIELD_W] == alarm_vec[g*FIELD_W +: FIELD_W]);
    end

    assign hit = sec_tick && (&eq);
endmodule

// File: rtl/pwa_trip.sv
module pwa_trip
    import pwa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic arm,
    output logic flag,
    output logic pwr_on
);
    trip_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit)           st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
        if (hit && arm)    st_d.pwr_on = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{flag: 1'b0, pwr_on: 1'b1};
        else        st_q <= st_d;
    end

    assign flag   = st_q.flag;
    assign pwr_on = st_q.pwr_on;
endmodule

// File: rtl/pwa_ctrl.sv
module pwa_ctrl
    import pwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    input  logic              sec_tick,
    input  logic [TIME_W-1:0] now_bcd,
    output logic              alarm_irq,
    output logic              pwr_en
);
    logic [TIME_W-1:0] alarm_vec;
    logic              arm, irq_gate, flag_clr, hit, flag, pwr_on;

    pwa_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .alarm_vec(alarm_vec), .arm(arm), .irq_gate(irq_gate), .flag_clr(flag_clr)
    );

    pwa_match u_match (
        .sec_tick(sec_tick), .now_bcd(now_bcd), .alarm_vec(alarm_vec), .hit(hit)
    );

    pwa_trip u_trip (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag_clr(flag_clr), .arm(arm),
        .flag(flag), .pwr_on(pwr_on)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < FIELDS; i++) begin
            if (addr == REG_AW'(i)) rdata[FIELD_W-1:0] = alarm_vec[i*FIELD_W +: FIELD_W];
        end
        if (addr == ADDR_CTRL) begin
            rdata[CTRL_ARM_BIT] = arm;
            rdata[CTRL_IRQ_BIT] = irq_gate;
        end
        if (addr == ADDR_STAT) begin
            rdata[STAT_FLAG_BIT] = flag;
            rdata[STAT_PWR_BIT]  = pwr_on;
        end
    end

    assign alarm_irq = flag && irq_gate;
    assign pwr_en    = pwr_on;
endmodule

// File: rtl/pwa_checker.sv
module pwa_checker
    import pwa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [TIME_W-1:0] now_bcd,
    input logic [TIME_W-1:0] alarm_vec,
    input logic              arm,
    input logic              flag,
    input logic              flag_clr,
    input logic              alarm_irq,
    input logic              pwr_en
);
    p_pwr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !pwr_en);

    p_pwr_drop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> ($past(sec_tick) && $past(arm)));

    p_flag_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sec_tick));

    p_flag_full_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(now_bcd == alarm_vec));

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> ($past(sec_tick) || $past(wr_en)));
endmodule

bind pwa_ctrl pwa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .now_bcd(now_bcd), .alarm_vec(alarm_vec), .arm(arm), .flag(flag),
    .flag_clr(flag_clr), .alarm_irq(alarm_irq), .pwr_en(pwr_en)
);

// File: tb/sim_pwa_ctrl.sv
`timescale 1ns/1ps
module sim_pwa_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        sec_tick;
    logic [47:0] now_bcd;
    logic        alarm_irq;
    logic        pwr_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwa_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_tick(sec_tick), .now_bcd(now_bcd),
        .alarm_irq(alarm_irq), .pwr_en(pwr_en)
    );

    // Target: 23:59:58 on day 31, month 12, year 99 (BCD)
    localparam logic [47:0] TGT = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        sec_tick = 1'b0; now_bcd = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(logic [47:0] t);
        @(negedge clk);
        now_bcd = t; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic load_target();
        for (int i = 0; i < 6; i++) wr(4'(i), {24'hFFFFFF, TGT[i*8 +: 8]});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
        check("R1 irq", {31'd0, alarm_irq}, 32'd0);
        rd(4'd7, d); check("R1 status", d, 32'h2);
        rd(4'd6, d); check("R1 ctrl", d, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rd(4'(i), d); check("R1 field", d, 32'h0);
        end
    endtask

    task automatic t_fields();
        logic [31:0] d;
        load_target();
        for (int i = 0; i < 6; i++) begin
            rd(4'(i), d); check("R2 field readback", d, {24'd0, TGT[i*8 +: 8]});
        end
    endtask

    task automatic t_no_tick();
        logic [31:0] d;
        @(negedge clk);
        now_bcd = TGT; sec_tick = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(4'd7, d); check("R3 no tick no flag", d[0], 1'b0);
    endtask

    task automatic t_mismatch();
        logic [31:0] d;
        for (int k = 0; k < 6; k++) begin
            logic [47:0] t;
            t = TGT;
            t[k*8 +: 8] = t[k*8 +: 8] ^ 8'h01;
            tick(t);
            rd(4'd7, d); check("R4 single field differs", d[0], 1'b0);
        end
    endtask

    task automatic t_hit_irq_clear();
        logic [31:0] d;
        wr(4'd6, 32'h0);
        tick(TGT);
        rd(4'd7, d); check("R5 flag set", d, 32'h3);
        check("R6 irq gated off", {31'd0, alarm_irq}, 32'd0);
        check("R8 pwr stays on", {31'd0, pwr_en}, 32'd1);
        wr(4'd6, 32'h2);
        check("R6 irq on", {31'd0, alarm_irq}, 32'd1);
        wr(4'd7, 32'h0);
        rd(4'd7, d); check("R5 write 0 keeps flag", d[0], 1'b1);
        wr(4'd7, 32'h1);
        rd(4'd7, d); check("R5 write 1 clears", d[0], 1'b0);
        check("R6 irq drops", {31'd0, alarm_irq}, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd7; wdata = 32'h1;
        now_bcd = TGT; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(4'd7, d); check("R9 set beats clear", d[0], 1'b1);
        wr(4'd7, 32'h1);
    endtask

    task automatic t_trip();
        logic [31:0] d;
        wr(4'd6, 32'h1);
        @(negedge clk);
        now_bcd = TGT; sec_tick = 1'b1;
        @(posedge clk); #1;
        check("R7 pwr low after edge", {31'd0, pwr_en}, 32'd0);
        @(negedge clk); sec_tick = 1'b0;
        rd(4'd7, d); check("R10 status pwr bit", d[1], 1'b0);
        wr(4'd7, 32'h1);
        wr(4'd6, 32'h0);
        repeat (3) @(negedge clk);
        check("R7 pwr stays low", {31'd0, pwr_en}, 32'd0);
        do_reset();
        check("R7 reset restores", {31'd0, pwr_en}, 32'd1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        load_target();
        for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFFFFFF);
        for (int a = 8; a < 16; a++) begin
            rd(4'(a), d); check("R10 unmapped reads 0", d, 32'h0);
        end
        rd(4'd6, d); check("R10 ctrl untouched", d, 32'h0);
        rd(4'd0, d); check("R10 field untouched", d, {24'd0, TGT[7:0]});
    endtask

    initial begin
        t_reset();
        t_fields();
        t_no_tick();
        t_mismatch();
        t_hit_irq_clear();
        t_collide();
        t_trip();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule